// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Sync Generator

This block produces the bit clock and the periodic frame-sync pulse for a synchronous serial port. It runs entirely in a fast peripheral clock domain. When the port masters its own clock, a reloading counter divides the peripheral clock down to a 50% duty serial clock. The divide ratio is twice as long when the port's data lines receive as when they transmit. When the clock comes from outside, the external pin is synchronised and its rising edges take the place of the internal ones.

A frame counter counts serial-clock rising edges from whichever source is active. It raises a sync pulse that lasts exactly one serial-clock period, once every programmed number of edges. The same pulse is routed to a transmit-sync or a receive-sync output according to the data direction. Two configuration words set the clock divisor and the frame spacing. New values are adopted only at a period or frame boundary. With only the master bit and the divisor set, the serial clock runs freely as a general-purpose clock.

Top module: `serial_clk_fs_gen`

## Requirements
- R1: After reset, and while en_i is low, sclk_o, sclk_edge_o, fs_o, fs_tx_o and fs_rx_o are all low.
- R2: With en_i=1, master_i=1 and dir_tx_i=1, sclk_o has a period of 4*(D+1) peripheral-clock cycles and is high for half of them. D is the divisor.
- R3: With en_i=1, master_i=1 and dir_tx_i=0, sclk_o has a period of 8*(D+1) peripheral-clock cycles and is high for half of them.
- R4: A write with cfg_sel_i=0 loads D from cfg_wdata_i[15:1]. Bit 0 of the written word has no effect on the clock.
- R5: With D=0 and transmit direction, the period is 4 peripheral-clock cycles.
- R6: A write with cfg_sel_i=1 loads the frame spacing F from cfg_wdata_i[15:0]. Counting serial-clock rising edges from 1 after enable, fs_o is set at edge k exactly when k is a multiple of F+1. fs_o holds its value until the next rising edge, so a pulse lasts one serial-clock period.
- R7: With master_i=0, each rising edge of ext_sclk_i yields exactly one single-cycle sclk_edge_o pulse a few cycles later. These pulses drive the frame counter of R6, and sclk_o stays low.
- R8: fs_tx_o follows fs_o when dir_tx_i=1 and fs_rx_o follows fs_o when dir_tx_i=0. The other output stays low.
- R9: A new divisor written while the clock runs does not alter the period already started. It applies from the next rising edge of sclk_o.
- R10: Deasserting en_i forces sclk_o and fs_o low on the next cycle and clears both counters. After en_i rises, the first sclk_o rising edge comes half a period (4*(D+1)/2 or 8*(D+1)/2 cycles) later.
- R11: sclk_edge_o is high for one peripheral-clock cycle per serial-clock rising edge. In master mode it is high in the same cycle in which sclk_o first reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Word select: 0 clock divisor, 1 frame spacing |
| cfg_wdata_i | input | 16 | Configuration write data |
| en_i | input | 1 | Port enable; low clears counters and outputs |
| master_i | input | 1 | 1: internal divided clock, 0: external clock |
| dir_tx_i | input | 1 | 1: data lines transmit, 0: receive |
| ext_sclk_i | input | 1 | External serial clock (asynchronous) |
| sclk_o | output | 1 | Generated serial clock |
| sclk_edge_o | output | 1 | One-cycle strobe per serial-clock rising edge |
| fs_o | output | 1 | Frame sync |
| fs_tx_o | output | 1 | Frame sync when transmitting |
| fs_rx_o | output | 1 | Frame sync when receiving |

## Verification
Two events can land on the same peripheral-clock edge: a serial-clock rising edge that wraps the frame counter, and the edge that latches a pending divisor or spacing value. With F=0 every edge is a wrap, so every edge that adopts a new divisor is also a sync edge. The bench writes a new divisor just after a rising edge and measures the next two periods, expecting the old length and then the new one. It also checks the sync level at each edge against the modulo-(F+1) edge index. Random runs mix divisors, directions, bit-0 values and spacings, and every interval and sync sample is compared with values derived from the formulas.

// File: rtl/sclk_fs_pkg.sv
package sclk_fs_pkg;
  typedef enum logic {
    CFG_CLK = 1'b0,
    CFG_FRM = 1'b1
  } cfg_sel_e;

  localparam int unsigned CFG_W = 16;
endpackage

// File: rtl/sclk_cfg_regs.sv
module sclk_cfg_regs
  import sclk_fs_pkg::*;
#(
  parameter int unsigned DIV_W = 15,
  parameter int unsigned FS_W  = 16,
  localparam int unsigned REG_W = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [DIV_W-1:0] div_o,
  output logic [FS_W-1:0]  fsdiv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o   <= '0;
      fsdiv_o <= '0;
    end else if (we_i) begin
      if (sel_i == CFG_CLK) div_o   <= wdata_i[REG_W-1:1];  // bit 0 reserved
      else                  fsdiv_o <= FS_W'(wdata_i);
    end
  end
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int unsigned DIV_W  = 15,
  localparam int unsigned HALF_W = DIV_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tx_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o
);
  logic [HALF_W-1:0] div_p1, half_new, half_act, cnt;
  logic              wrap;

  assign div_p1   = HALF_W'(div_i) + HALF_W'(1);
  // half period: 2*(D+1) transmit, 4*(D+1) receive
  assign half_new = tx_i ? (div_p1 << 1) : (div_p1 << 2);
  assign wrap     = (cnt == half_act - HALF_W'(1));
  assign rise_o   = run_i && wrap && !sclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      sclk_o   <= 1'b0;
      half_act <= HALF_W'(2);
    end else if (!run_i) begin
      cnt      <= '0;
      sclk_o   <= 1'b0;
      half_act <= half_new;
    end else if (wrap) begin
      cnt    <= '0;
      sclk_o <= ~sclk_o;
      if (!sclk_o) half_act <= half_new;  // adopt only at period start
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < half_act);
  assert_half_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !rise_o) |=> $stable(half_act));
endmodule

// File: rtl/sclk_ext_sync.sv
module sclk_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[STAGES-1:0], ext_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int unsigned FS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic [FS_W-1:0] fsdiv_i,
  output logic            fs_o
);
  logic [FS_W-1:0] fcnt, fsdiv_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt      <= '0;
      fsdiv_act <= '0;
      fs_o      <= 1'b0;
    end else if (!en_i) begin
      fcnt      <= '0;
      fsdiv_act <= fsdiv_i;
      fs_o      <= 1'b0;
    end else if (tick_i) begin
      if (fcnt == fsdiv_act) begin
        fcnt      <= '0;
        fs_o      <= 1'b1;
        fsdiv_act <= fsdiv_i;
      end else begin
        fcnt <= fcnt + FS_W'(1);
        fs_o <= 1'b0;
      end
    end
  end

  assert_fs_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(fs_o));
  assert_fcnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcnt <= fsdiv_act);
endmodule

// File: rtl/serial_clk_fs_gen.sv
module serial_clk_fs_gen
  import sclk_fs_pkg::*;
#(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned FS_W   = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [DIV_W:0]   cfg_wdata_i,
  input  logic             en_i,
  input  logic             master_i,
  input  logic             dir_tx_i,
  input  logic             ext_sclk_i,
  output logic             sclk_o,
  output logic             sclk_edge_o,
  output logic             fs_o,
  output logic             fs_tx_o,
  output logic             fs_rx_o
);
  logic [DIV_W-1:0] div;
  logic [FS_W-1:0]  fsdiv;
  logic             int_rise, ext_rise, tick, edge_q;

  sclk_cfg_regs #(.DIV_W(DIV_W), .FS_W(FS_W)) u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .div_o(div), .fsdiv_o(fsdiv)
  );

  sclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(en_i & master_i), .tx_i(dir_tx_i),
    .div_i(div), .sclk_o(sclk_o), .rise_o(int_rise)
  );

  sclk_ext_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .ext_i(ext_sclk_i), .rise_o(ext_rise)
  );

  assign tick = master_i ? int_rise : (en_i & ext_rise);

  fsync_gen #(.FS_W(FS_W)) u_fs (
    .clk_i, .rst_ni, .en_i, .tick_i(tick), .fsdiv_i(fsdiv), .fs_o(fs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= 1'b0;
    else         edge_q <= en_i & tick;
  end

  assign sclk_edge_o = edge_q;
  assign fs_tx_o     = fs_o & dir_tx_i;
  assign fs_rx_o     = fs_o & ~dir_tx_i;

  assert_off_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sclk_o && !fs_o && !sclk_edge_o));
  assert_edge_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_edge_o |=> !sclk_edge_o);
  assert_edge_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && sclk_edge_o) |-> sclk_o);
endmodule

// File: tb/serial_clk_fs_gen_test.sv
module serial_clk_fs_gen_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic        en_i = 1'b0, master_i = 1'b0, dir_tx_i = 1'b1, ext_sclk_i = 1'b0;
  logic        sclk_o, sclk_edge_o, fs_o, fs_tx_o, fs_rx_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  serial_clk_fs_gen uut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int half_of(input int d, input bit tx);
    return tx ? 2 * (d + 1) : 4 * (d + 1);
  endfunction

  function automatic bit fs_exp(input int k, input int f);
    return (k % (f + 1)) == 0;
  endfunction

  task automatic wr(input bit sel, input logic [15:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // enable with given setup, then check intervals, duty and sync for ne edges
  task automatic run_master(input int d, input bit tx, input int f, input bit b0, input int ne);
    int h, k, last, hi, bad_hold, t;
    bit fs_prev;
    en_i = 1'b0; master_i = 1'b1; dir_tx_i = tx;
    wr(1'b0, {d[14:0], b0});
    wr(1'b1, f[15:0]);
    @(negedge clk_i);
    en_i = 1'b1;
    h = half_of(d, tx);
    k = 0; last = 0; hi = 0; bad_hold = 0; t = 0; fs_prev = 1'b0;
    while (k < ne && t < 4000) begin
      @(negedge clk_i);
      t++;
      if (sclk_edge_o) begin
        k++;
        if (k == 1) chk(t == h, "R10 first rise delay", t, h);
        else begin
          chk(t - last == 2 * h, tx ? "R2 tx period" : "R3 rx period", t - last, 2 * h);
          chk(hi == h, "R2/R3 high time R2 R3", hi, h);
        end
        chk(sclk_o == 1'b1, "R11 strobe with high clock", int'(sclk_o), 1);
        chk(fs_o == fs_exp(k, f), "R6 sync at edge", int'(fs_o), int'(fs_exp(k, f)));
        chk(fs_tx_o == (fs_o & tx) && fs_rx_o == (fs_o & ~tx), "R8 sync routing",
            int'({fs_tx_o, fs_rx_o}), int'({fs_o & tx, fs_o & ~tx}));
        last = t; hi = 0; fs_prev = fs_o;
      end else if (k > 0 && fs_o != fs_prev) bad_hold++;
      if (sclk_o) hi++;
    end
    chk(k == ne, "R2 edges seen", k, ne);
    chk(bad_hold == 0, "R6 sync held between edges", bad_hold, 0);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk({sclk_o, sclk_edge_o, fs_o, fs_tx_o, fs_rx_o} == 5'b0, "R1 in reset",
        int'({sclk_o, sclk_edge_o, fs_o, fs_tx_o, fs_rx_o}), 0);
    rst_ni = 1'b1;
    master_i = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk_i);
        if (sclk_o | sclk_edge_o | fs_o | fs_tx_o | fs_rx_o) seen++;
      end
      chk(seen == 0, "R1 idle while disabled", seen, 0);
    end

    run_master(0, 1'b1, 0, 1'b0, 6);   // R5 fastest clock
    run_master(0, 1'b0, 1, 1'b1, 6);   // R3 fastest receive
    run_master(1, 1'b1, 2, 1'b1, 8);   // R4 bit 0 set, same as D=1
    run_master(1, 1'b1, 2, 1'b0, 8);   // R4 bit 0 clear
    run_master(3, 1'b0, 3, 1'b0, 9);

    for (int r = 0; r < 12; r++) begin
      int d = int'($urandom_range(0, 6));
      int f = int'($urandom_range(0, 4));
      bit tx = 1'(($urandom() >> 3) & 1);
      bit b0 = 1'(($urandom() >> 5) & 1);
      run_master(d, tx, f, b0, 2 * (f + 1) + 2);
    end

    // R10: disable mid-run forces outputs low next cycle
    begin
      int hc = 0;
      while (!sclk_o && hc < 200) begin @(negedge clk_i); hc++; end
      en_i = 1'b0;
      @(negedge clk_i);
      chk(!sclk_o && !fs_o, "R10 disable forces low", int'({sclk_o, fs_o}), 0);
    end

    // R9: divisor change mid-period
    begin
      int t = 0, k = 0, last = 0;
      master_i = 1'b1; dir_tx_i = 1'b1;
      wr(1'b0, 16'h0002);  // D=1, half=4
      wr(1'b1, 16'h0000);
      @(negedge clk_i);
      en_i = 1'b1;
      while (k < 3 && t < 500) begin
        @(negedge clk_i);
        t++;
        cfg_we_i = 1'b0;
        if (sclk_edge_o) begin
          k++;
          if (k == 1) begin
            cfg_we_i = 1'b1; cfg_sel_i = 1'b0; cfg_wdata_i = 16'h0006;  // D=3
          end else if (k == 2) chk(t - last == 8, "R9 started period kept", t - last, 8);
          else chk(t - last == 16, "R9 new divisor applied", t - last, 16);
          last = t;
        end
      end
      cfg_we_i = 1'b0;
      chk(k == 3, "R9 edges seen", k, 3);
      en_i = 1'b0;
    end

    // R7: external clock, F=2, receive
    begin
      int strobes = 0, sclk_hi = 0, fs_bad = 0, rx_bad = 0;
      @(negedge clk_i);
      master_i = 1'b0; dir_tx_i = 1'b0; ext_sclk_i = 1'b0;
      wr(1'b1, 16'h0002);
      @(negedge clk_i);
      en_i = 1'b1;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk_i);
        if (sclk_o) sclk_hi++;
        if (sclk_edge_o) begin
          strobes++;
          if (fs_o != fs_exp(strobes, 2)) fs_bad++;
          if (fs_rx_o != fs_o || fs_tx_o) rx_bad++;
        end
        ext_sclk_i = (i < 90) && ((i % 10) < 5);
      end
      chk(strobes == 9, "R7 one strobe per external edge", strobes, 9);
      chk(sclk_hi == 0, "R7 sclk_o low in slave mode", sclk_hi, 0);
      chk(fs_bad == 0, "R7 R6 sync from external edges", fs_bad, 0);
      chk(rx_bad == 0, "R8 receive routing", rx_bad, 0);
      en_i = 1'b0;
    end

    @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule